// File: doc/BRIEF.md
# Paged Host Register Interface

This block is the host-facing register file of a network controller. It has a 16-bit synchronous read/write strobe port. Four registers always sit at the bottom of the address space: a hardware identifier, a page selector that also carries a chip identifier, and two option registers. Above them is a window that shows one of eight pages, and the page selector picks which one. Page 0 holds the interrupt status register, the interrupt mask and a readback of the transmit free-byte count. Page 2 holds the mode-control register.

The datapath core feeds the block with single-cycle event pulses and a live transmit free-byte count. In return the block drives an interrupt line, a level reset hold, a single-cycle soft-reset pulse, and two command request levels. The host sets each command request, and the core clears it with a done pulse.

Status bits clear in one of two ways. In the default mode the host writes ones to the bits it wants cleared. With the clear-on-read mode bit set, any read of the status register clears all pending bits. An event that arrives in the same cycle as a clear always survives that clear.

Top module: `hostreg_pager`

## Requirements
- R1: After reset the option, mask, mode, status, page and trace registers read 0. The core is held in reset (`core_hold_rst`=1) and `irq` is 0.
- R2: A read of offset 0x00 returns 0x4850 on every page. A write to 0x00 loads `trace_out` and does not change what offset 0x00 reads.
- R3: A write to offset 0x02 selects the page from data bits 2:0 and ignores every other data bit. A read of 0x02 returns the chip identifier 0x5A3 in bits 15:4 and the page in bits 3:0, with bit 3 always 0.
- R4: Offsets 0x00 to 0x06 decode the same way on every page. Page 0 maps status at 0x08, mask at 0x0A and the free-byte count at 0x14. Page 2 maps mode control at 0x10, using data bits 7:0. Every other window location reads 0 and ignores writes, and `cpu_rdata` is 0 while `cpu_rd` is low.
- R5: Event pulses latch sticky status bits at fixed positions: receive packet at bit 10, receive error at bit 9, transmit complete at bit 3, miscellaneous error at bit 2 and transmit error at bit 1.
- R6: Status bit 4 is 1 exactly when `tx_free_bytes` is at least 8192. It follows the input live and no clear affects it.
- R7: With mode bit 1 at 0, writing a 1 to a sticky status bit clears it, and a written 0 leaves the bit unchanged.
- R8: With mode bit 1 at 1, a status read returns the pending bits and clears all sticky bits at that clock edge. Writes to the status register then have no effect.
- R9: An event arriving in the same cycle as a clear of its bit, whether by write or by read, leaves the bit set.
- R10: `irq` = option-low bit 2 AND (option-low bit 3 OR any bit of status AND mask).
- R11: `core_hold_rst` is the inverse of option-low bit 1. `core_soft_rst` pulses for one cycle after a write that changes that bit from 0 to 1, and only then.
- R12: Option-high bits 1 and 2 drive `tx_cmd_req` and `rx_adv_req`. A `tx_cmd_done` or `rx_adv_done` pulse clears the matching bit, but a host write to option-high in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | 6 | Byte offset, bit 0 ignored |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid in the strobe cycle |
| ev_rx_pkt | input | 1 | Receive packet event pulse |
| ev_rx_err | input | 1 | Receive error event pulse |
| ev_tx_done | input | 1 | Transmit complete event pulse |
| ev_misc_err | input | 1 | Miscellaneous error event pulse |
| ev_tx_err | input | 1 | Transmit error event pulse |
| tx_free_bytes | input | 16 | Free transmit buffer bytes |
| tx_cmd_done | input | 1 | Core finished the transmit command |
| rx_adv_done | input | 1 | Core finished advancing the receive queue |
| irq | output | 1 | Interrupt request |
| core_hold_rst | output | 1 | Holds the core in reset |
| core_soft_rst | output | 1 | One-cycle reset pulse |
| tx_cmd_req | output | 1 | Transmit command pending |
| rx_adv_req | output | 1 | Receive advance pending |
| trace_out | output | 16 | Last value written to offset 0x00 |

## Verification
Two pairs of actions can land in the same cycle: a status clear together with the event that sets the same bit, and a command-done pulse together with a host write to the command register. The bench applies each pair in one strobe cycle. It applies the status clear both as a ones-write and as a clear-on-read access. It then reads the status back, or samples the request pins, on the next access. A surviving bit or request counts as correct, and a lost one as a miscompare.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;

  // byte offsets of the always-visible registers
  localparam logic [ADDR_W-1:0] OFF_ID     = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_PAGE   = 6'h02;
  localparam logic [ADDR_W-1:0] OFF_OPT_LO = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_OPT_HI = 6'h06;
  localparam logic [ADDR_W-1:0] WIN_BASE   = 6'h08;
  // window offsets
  localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h0A;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_FREE   = 6'h14;
  localparam int PG_PERF = 0;
  localparam int PG_MAP  = 2;

  // status bit positions
  localparam int ST_TX_ERR   = 1;
  localparam int ST_MISC     = 2;
  localparam int ST_TX_DONE  = 3;
  localparam int ST_TX_SPACE = 4;
  localparam int ST_RX_ERR   = 9;
  localparam int ST_RX_PKT   = 10;
  localparam logic [DATA_W-1:0] STICKY_MASK =
    (16'd1 << ST_TX_ERR) | (16'd1 << ST_MISC) | (16'd1 << ST_TX_DONE) |
    (16'd1 << ST_RX_ERR) | (16'd1 << ST_RX_PKT);

  // option / mode bit positions
  localparam int OPT_RUN     = 1;
  localparam int OPT_IRQ_EN  = 2;
  localparam int OPT_FORCE   = 3;
  localparam int CMD_TX      = 1;
  localparam int CMD_ADV     = 2;
  localparam int MODE_COR    = 1;

  typedef struct packed {
    logic hw_id;
    logic page;
    logic opt_lo;
    logic opt_hi;
    logic stat;
    logic mask;
    logic mode;
    logic free;
  } sel_t;
endpackage

// File: rtl/hostreg_dec.sv
module hostreg_dec
  import hostreg_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output sel_t              sel
);
  logic [ADDR_W-1:0] word;
  logic              common;
  logic              on_perf;
  logic              on_map;
  logic              unused_lsb;

  assign word       = {addr[ADDR_W-1:1], 1'b0};
  assign unused_lsb = addr[0];
  assign common     = (word < WIN_BASE);
  assign on_perf    = !common && (page == PAGE_W'(PG_PERF));
  assign on_map     = !common && (page == PAGE_W'(PG_MAP));

  always_comb begin
    sel        = '0;
    sel.hw_id  = common && (word == OFF_ID);
    sel.page   = common && (word == OFF_PAGE);
    sel.opt_lo = common && (word == OFF_OPT_LO);
    sel.opt_hi = common && (word == OFF_OPT_HI);
    sel.stat   = on_perf && (word == OFF_STAT);
    sel.mask   = on_perf && (word == OFF_MASK);
    sel.free   = on_perf && (word == OFF_FREE);
    sel.mode   = on_map  && (word == OFF_MODE);
  end
endmodule

// File: rtl/hostreg_stat.sv
module hostreg_stat
  import hostreg_pkg::*;
#(
  parameter int FREE_W      = 16,
  parameter int SPACE_THRESH = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ev_in,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic              cor_mode,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FREE_W-1:0] free_cnt,
  output logic [DATA_W-1:0] stat
);
  logic [DATA_W-1:0] clr;
  logic              unused_bits;

  // clear vector: whole sticky set on a read in clear-on-read mode,
  // written ones otherwise
  assign clr = cor_mode ? {DATA_W{rd_hit}} : (wr_hit ? wdata : '0);
  assign unused_bits = ^(wdata & ~STICKY_MASK) ^ ^(ev_in & ~STICKY_MASK);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ev_in[i] | (q & ~clr[i]);
      end
      assign stat[i] = q;
    end else if (i == ST_TX_SPACE) begin : g_space
      assign stat[i] = (free_cnt >= FREE_W'(SPACE_THRESH));
    end else begin : g_none
      assign stat[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hostreg_opt.sv
module hostreg_opt
  import hostreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_done,
  input  logic              adv_done,
  output logic [DATA_W-1:0] opt_lo,
  output logic [DATA_W-1:0] opt_hi,
  output logic              soft_rst
);
  logic [DATA_W-1:0] done_clr;

  always_comb begin
    done_clr          = '0;
    done_clr[CMD_TX]  = tx_done;
    done_clr[CMD_ADV] = adv_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_lo   <= '0;
      opt_hi   <= '0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= wr_lo && wdata[OPT_RUN] && !opt_lo[OPT_RUN];
      if (wr_lo) opt_lo <= wdata;
      // a host write wins over a completion in the same cycle
      if (wr_hi) opt_hi <= wdata;
      else       opt_hi <= opt_hi & ~done_clr;
    end
  end
endmodule

// File: rtl/hostreg_pager.sv
module hostreg_pager
  import hostreg_pkg::*;
#(
  parameter logic [15:0] HW_ID        = 16'h4850,
  parameter logic [11:0] CHIP_ID      = 12'h5A3,
  parameter int          NUM_PAGES    = 8,
  parameter int          SPACE_THRESH = 8192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [5:0]  cpu_addr,
  input  logic [15:0] cpu_wdata,
  output logic [15:0] cpu_rdata,
  input  logic        ev_rx_pkt,
  input  logic        ev_rx_err,
  input  logic        ev_tx_done,
  input  logic        ev_misc_err,
  input  logic        ev_tx_err,
  input  logic [15:0] tx_free_bytes,
  input  logic        tx_cmd_done,
  input  logic        rx_adv_done,
  output logic        irq,
  output logic        core_hold_rst,
  output logic        core_soft_rst,
  output logic        tx_cmd_req,
  output logic        rx_adv_req,
  output logic [15:0] trace_out
);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam int MODE_W = 8;

  sel_t              sel;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] mask_q;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] trace_q;
  logic [DATA_W-1:0] opt_lo_q;
  logic [DATA_W-1:0] opt_hi_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] ev_vec;

  hostreg_dec #(.PAGE_W(PAGE_W)) u_dec (
    .addr (cpu_addr),
    .page (page_q),
    .sel  (sel)
  );

  always_comb begin
    ev_vec             = '0;
    ev_vec[ST_RX_PKT]  = ev_rx_pkt;
    ev_vec[ST_RX_ERR]  = ev_rx_err;
    ev_vec[ST_TX_DONE] = ev_tx_done;
    ev_vec[ST_MISC]    = ev_misc_err;
    ev_vec[ST_TX_ERR]  = ev_tx_err;
  end

  hostreg_stat #(.FREE_W(16), .SPACE_THRESH(SPACE_THRESH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_in    (ev_vec),
    .wr_hit   (cpu_wr && sel.stat),
    .rd_hit   (cpu_rd && sel.stat),
    .cor_mode (mode_q[MODE_COR]),
    .wdata    (cpu_wdata),
    .free_cnt (tx_free_bytes),
    .stat     (stat_q)
  );

  hostreg_opt u_opt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (cpu_wr && sel.opt_lo),
    .wr_hi    (cpu_wr && sel.opt_hi),
    .wdata    (cpu_wdata),
    .tx_done  (tx_cmd_done),
    .adv_done (rx_adv_done),
    .opt_lo   (opt_lo_q),
    .opt_hi   (opt_hi_q),
    .soft_rst (core_soft_rst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      mask_q  <= '0;
      mode_q  <= '0;
      trace_q <= '0;
    end else if (cpu_wr) begin
      if (sel.hw_id) trace_q <= cpu_wdata;
      if (sel.page)  page_q  <= cpu_wdata[PAGE_W-1:0];
      if (sel.mask)  mask_q  <= cpu_wdata;
      if (sel.mode)  mode_q  <= cpu_wdata[MODE_W-1:0];
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      unique case (1'b1)
        sel.hw_id:  cpu_rdata = HW_ID;
        sel.page:   cpu_rdata = {CHIP_ID, 4'(page_q)};
        sel.opt_lo: cpu_rdata = opt_lo_q;
        sel.opt_hi: cpu_rdata = opt_hi_q;
        sel.stat:   cpu_rdata = stat_q;
        sel.mask:   cpu_rdata = mask_q;
        sel.mode:   cpu_rdata = DATA_W'(mode_q);
        sel.free:   cpu_rdata = tx_free_bytes;
        default:    cpu_rdata = '0;
      endcase
    end
  end

  assign irq = opt_lo_q[OPT_IRQ_EN] &&
               (opt_lo_q[OPT_FORCE] || |(stat_q & mask_q));
  assign core_hold_rst = !opt_lo_q[OPT_RUN];
  assign tx_cmd_req    = opt_hi_q[CMD_TX];
  assign rx_adv_req    = opt_hi_q[CMD_ADV];
  assign trace_out     = trace_q;
endmodule

// File: rtl/hostreg_pager_chk.sv
module hostreg_pager_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic [5:0]  cpu_addr,
  input logic        ev_rx_pkt,
  input logic        tx_cmd_done,
  input logic        irq,
  input logic        core_hold_rst,
  input logic        core_soft_rst,
  input logic        tx_cmd_req,
  input logic [2:0]  page_q,
  input logic [15:0] stat_q,
  input logic [15:0] opt_lo_q
);
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[5:1] == 5'd1) |=> $stable(page_q)); // R3

  AST_EVENT_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> stat_q[10]); // R9

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> opt_lo_q[2]); // R10

  AST_SOFT_RST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    core_soft_rst |-> (!core_hold_rst && $past(core_hold_rst))); // R11

  AST_SOFT_RST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    core_soft_rst |=> !core_soft_rst); // R11

  AST_CMD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cmd_done && !(cpu_wr && cpu_addr[5:1] == 5'd3)) |=> !tx_cmd_req); // R12
endmodule

bind hostreg_pager hostreg_pager_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_wr        (cpu_wr),
  .cpu_addr      (cpu_addr),
  .ev_rx_pkt     (ev_rx_pkt),
  .tx_cmd_done   (tx_cmd_done),
  .irq           (irq),
  .core_hold_rst (core_hold_rst),
  .core_soft_rst (core_soft_rst),
  .tx_cmd_req    (tx_cmd_req),
  .page_q        (page_q),
  .stat_q        (stat_q),
  .opt_lo_q      (opt_lo_q)
);

// File: tb/hostreg_pager_bench.sv
module hostreg_pager_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [15:0] evb = '0;
  logic [15:0] tx_free_bytes = '0;
  logic        tx_cmd_done = 1'b0, rx_adv_done = 1'b0;
  logic        irq, core_hold_rst, core_soft_rst, tx_cmd_req, rx_adv_req;
  logic [15:0] trace_out;
  int          n_vec = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  hostreg_pager u_hostreg_pager (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ev_rx_pkt(evb[10]), .ev_rx_err(evb[9]), .ev_tx_done(evb[3]),
    .ev_misc_err(evb[2]), .ev_tx_err(evb[1]), .tx_free_bytes(tx_free_bytes),
    .tx_cmd_done(tx_cmd_done), .rx_adv_done(rx_adv_done), .irq(irq),
    .core_hold_rst(core_hold_rst), .core_soft_rst(core_soft_rst),
    .tx_cmd_req(tx_cmd_req), .rx_adv_req(rx_adv_req), .trace_out(trace_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one strobe cycle; returns at the falling edge after the clock edge
  task automatic op(input bit w, input bit r, input [5:0] a, input [15:0] d,
                    input [15:0] ev, input [1:0] dn, output [15:0] q);
    @(negedge clk);
    cpu_wr = w; cpu_rd = r; cpu_addr = a; cpu_wdata = d; evb = ev;
    tx_cmd_done = dn[0]; rx_adv_done = dn[1];
    #1 q = cpu_rdata;
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; evb = '0; tx_cmd_done = 0; rx_adv_done = 0;
  endtask

  task automatic wr(input [5:0] a, input [15:0] d);
    logic [15:0] q;
    op(1, 0, a, d, '0, 2'b00, q);
  endtask

  task automatic rd(input [5:0] a, output [15:0] q);
    op(0, 1, a, '0, '0, 2'b00, q);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] q, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 hold", {15'd0, core_hold_rst}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 trace", trace_out, 16'd0);
    rd(6'h02, q); chk("R1 page", q, 16'h5A30);
    rd(6'h04, q); chk("R1 optlo", q, 16'd0);
    rd(6'h08, q); chk("R1 stat", q, 16'd0);

    // R2 trace write
    wr(6'h00, 16'hBEEF);
    chk("R2 trace", trace_out, 16'hBEEF);
    rd(6'h00, q); chk("R2 id", q, 16'h4850);

    // R11 reset control
    wr(6'h04, 16'h0002);
    chk("R11 pulse", {15'd0, core_soft_rst}, 16'd1);
    chk("R11 hold", {15'd0, core_hold_rst}, 16'd0);
    @(negedge clk);
    chk("R11 one cycle", {15'd0, core_soft_rst}, 16'd0);
    wr(6'h04, 16'h0002);
    chk("R11 no repulse", {15'd0, core_soft_rst}, 16'd0);
    wr(6'h04, 16'h0000);
    chk("R11 hold again", {15'd0, core_hold_rst}, 16'd1);
    wr(6'h04, 16'h0002);

    // state for the sweep
    wr(6'h02, 16'h0000);
    wr(6'h0A, 16'h0A5A);
    wr(6'h02, 16'h0002);
    wr(6'h10, 16'hFFC4);
    wr(6'h06, 16'h8100);
    tx_free_bytes = 16'd5000;

    // R4 R3 R2 sweep of every page and offset
    for (int p = 0; p < 8; p++) begin
      wr(6'h02, {12'hABC, 1'b1, 3'(p)});
      for (int o = 0; o < 64; o += 2) begin
        rd(6'(o), q);
        exp = 16'd0;
        if (o == 0) exp = 16'h4850;
        else if (o == 2) exp = {12'h5A3, 4'(p)};
        else if (o == 4) exp = 16'h0002;
        else if (o == 6) exp = 16'h8100;
        else if (p == 0 && o == 8'h08) exp = 16'h0000;
        else if (p == 0 && o == 8'h0A) exp = 16'h0A5A;
        else if (p == 0 && o == 8'h14) exp = 16'd5000;
        else if (p == 2 && o == 8'h10) exp = 16'h00C4;
        chk(o == 0 ? "R2 sweep" : (o == 2 ? "R3 sweep" : "R4 sweep"), q, exp);
      end
    end
    // R4 writes to other pages ignored, rdata zero without strobe
    wr(6'h02, 16'h0005);
    wr(6'h0A, 16'hFFFF);
    wr(6'h10, 16'hFFFF);
    wr(6'h02, 16'h0000);
    rd(6'h0A, q); chk("R4 mask kept", q, 16'h0A5A);
    #1 chk("R4 idle rdata", cpu_rdata, 16'd0);

    // R5 sticky bits
    op(0, 0, 6'h0, 16'h0, 16'h060E, 2'b00, q);
    rd(6'h08, q); chk("R5 latch", q, 16'h060E);
    rd(6'h08, q); chk("R5 sticky", q, 16'h060E);
    // R7 write-one clear
    wr(6'h08, 16'h0008); rd(6'h08, q); chk("R7 w1c", q, 16'h0606);
    wr(6'h08, 16'h0000); rd(6'h08, q); chk("R7 w0", q, 16'h0606);
    // R9 event beats write clear
    op(1, 0, 6'h08, 16'h0400, 16'h0400, 2'b00, q);
    rd(6'h08, q); chk("R9 write clash", q, 16'h0606);
    wr(6'h08, 16'hFFFF); rd(6'h08, q); chk("R7 clear all", q, 16'h0000);

    // R6 live space bit
    tx_free_bytes = 16'd9000;
    rd(6'h08, q); chk("R6 above", q, 16'h0010);
    wr(6'h08, 16'h0010); rd(6'h08, q); chk("R6 no clear", q, 16'h0010);
    tx_free_bytes = 16'd8191; rd(6'h08, q); chk("R6 8191", q, 16'h0000);
    tx_free_bytes = 16'd8192; rd(6'h08, q); chk("R6 8192", q, 16'h0010);
    tx_free_bytes = 16'd0;

    // R10 interrupt
    wr(6'h0A, 16'h0400);
    op(0, 0, 6'h0, 16'h0, 16'h0400, 2'b00, q);
    chk("R10 disabled", {15'd0, irq}, 16'd0);
    wr(6'h04, 16'h0006);
    chk("R10 masked event", {15'd0, irq}, 16'd1);
    wr(6'h08, 16'h0400);
    chk("R10 cleared", {15'd0, irq}, 16'd0);
    op(0, 0, 6'h0, 16'h0, 16'h0200, 2'b00, q);
    chk("R10 unmasked bit", {15'd0, irq}, 16'd0);
    wr(6'h04, 16'h000E);
    chk("R10 force", {15'd0, irq}, 16'd1);
    wr(6'h04, 16'h0002);
    wr(6'h08, 16'hFFFF);

    // R8 clear on read
    wr(6'h02, 16'h0002); wr(6'h10, 16'h0002); wr(6'h02, 16'h0000);
    op(0, 0, 6'h0, 16'h0, 16'h060E, 2'b00, q);
    rd(6'h08, q); chk("R8 read value", q, 16'h060E);
    rd(6'h08, q); chk("R8 cleared", q, 16'h0000);
    op(0, 0, 6'h0, 16'h0, 16'h0008, 2'b00, q);
    wr(6'h08, 16'hFFFF); rd(6'h08, q); chk("R8 write ignored", q, 16'h0008);
    // R9 event beats read clear
    op(0, 1, 6'h08, 16'h0, 16'h0002, 2'b00, q);
    chk("R9 read value", q, 16'h0000);
    rd(6'h08, q); chk("R9 read clash", q, 16'h0002);

    // R12 command bits
    wr(6'h06, 16'h0006);
    chk("R12 tx set", {15'd0, tx_cmd_req}, 16'd1);
    chk("R12 adv set", {15'd0, rx_adv_req}, 16'd1);
    op(0, 0, 6'h0, 16'h0, 16'h0, 2'b01, q);
    chk("R12 tx done", {15'd0, tx_cmd_req}, 16'd0);
    chk("R12 adv kept", {15'd0, rx_adv_req}, 16'd1);
    op(0, 0, 6'h0, 16'h0, 16'h0, 2'b10, q);
    chk("R12 adv done", {15'd0, rx_adv_req}, 16'd0);
    op(1, 0, 6'h06, 16'h0002, 16'h0, 2'b01, q);
    chk("R12 write wins", {15'd0, tx_cmd_req}, 16'd1);
    rd(6'h06, q); chk("R12 readback", q, 16'h0002);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule